// File: doc/BRIEF.md
# Associative Range-Split Cell Array

The block is a small content-addressed store of cells. Each cell holds a tag, a value and a valid bit, plus three flags: select, saved and less. A command is broadcast to every cell at once together with a key. All cells evaluate the command in parallel in one clock, so locating a tag or marking a range takes one command rather than a walk over the cells.

A fixed command sequence performs one partition step of a quicksort-style sort with no loop. The sequence is: select every cell, drop cells whose tag is below a lower bound, drop cells whose tag is above an upper bound, save the survivors, then compare each saved cell's value against a splitting value. After the last command, `saved_flags` marks the cells in the range and `less_flags` marks the range members whose value is smaller than the split. The remaining saved cells form the larger subset. `any_match` reports whether any cell is saved.

A single write port loads one cell's tag and value per clock and marks that cell valid. All flags are registers, and `any_match` is registered in step with them.

Top module: `assoc_tag_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all select, saved and less flags and `any_match` are 0. Every cell is invalid after reset, so no cell passes a bound or search match until it has been written.
- R2: With `wr_en` high, the cell at `wr_addr` takes `wr_tag` and `wr_value` and becomes valid. A write changes no flag. A command issued in the same cycle as a write uses the cell's previous contents.
- R3: `cmd_op`=1 (select-all) sets every select flag to 1. Saved and less flags are unchanged.
- R4: `cmd_op`=3 (lower-bound match) clears the select flag of every cell that is invalid or whose tag is below `cmd_key`. The bound is inclusive, and no select flag is set by this command.
- R5: `cmd_op`=4 (upper-bound match) clears the select flag of every cell that is invalid or whose tag is above `cmd_key`. The bound is inclusive, and no select flag is set by this command.
- R6: `cmd_op`=5 (save) copies every select flag into the saved flag and clears every less flag.
- R7: `cmd_op`=6 (compare) sets a cell's less flag exactly when the cell is saved and its value is strictly below `cmd_key`. An equal value gives 0. Select and saved flags are unchanged.
- R8: `cmd_op`=2 (search) sets both the select and the saved flag of every valid cell whose tag equals `cmd_key`, clears them for all other cells, and clears every less flag.
- R9: `cmd_op`=7 (clear) sets all select, saved and less flags to 0.
- R10: `cmd_op`=0 (idle) leaves all flags unchanged.
- R11: `any_match` equals the OR of all saved flags in every cycle and changes on the same clock edge as they do. A less flag is never set on a cell that is not saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 3 | Broadcast command code (see R3 to R10) |
| cmd_key | input | 8 | Bound, search tag or split value for the command |
| wr_en | input | 1 | Write one cell this cycle |
| wr_addr | input | 4 | Index of the cell to write |
| wr_tag | input | 8 | Tag to store |
| wr_value | input | 8 | Value to store |
| sel_flags | output | 16 | Select flag of each cell, bit i for cell i |
| saved_flags | output | 16 | Saved flag of each cell |
| less_flags | output | 16 | Less flag of each cell |
| any_match | output | 1 | OR of all saved flags |

## Verification
Every flag is a port, so a cell whose stored tag, value or valid bit is wrong shows up on the first command that touches that cell. A bad tag or valid bit appears in `sel_flags` one edge after a bound or search command. A bad value appears in `less_flags` one edge after a compare. The bench keeps its own copy of every cell and every flag, and it compares all three flag vectors and `any_match` after every command. A fault therefore appears at the command where it first has an effect, and cannot surface only later in a chain of commands. Equal-to-bound tags, equal-to-split values, crossed bounds and unwritten cells are driven on purpose, because an off-by-one comparison is visible only there.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  // Broadcast command codes; the numeric values are part of the port contract.
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_SEL_ALL  = 3'd1,
    OP_SEARCH   = 3'd2,
    OP_BOUND_LO = 3'd3,
    OP_BOUND_HI = 3'd4,
    OP_SAVE     = 3'd5,
    OP_COMPARE  = 3'd6,
    OP_CLEAR    = 3'd7
  } op_e;

endpackage

// File: rtl/assoc_wr_decode.sv
module assoc_wr_decode #(
  parameter int CELLS  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [CELLS-1:0]  wr_hit
);

  // One-hot write strobe, one bit per cell.
  for (genvar i = 0; i < CELLS; i++) begin : g_hit
    assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

endmodule

// File: rtl/assoc_cell.sv
module assoc_cell
  import assoc_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int VAL_W = 8,
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [VAL_W-1:0] wr_value,
  input  op_e              op,
  input  logic [KEY_W-1:0] key,
  output logic             sel_o,
  output logic             saved_o,
  output logic             less_o,
  output logic             saved_nxt_o
);

  logic [TAG_W-1:0] tag_q;
  logic [VAL_W-1:0] val_q;
  logic             vld_q;
  logic             sel_q, sav_q, less_q;
  logic             sel_n, sav_n, less_n;
  logic [KEY_W-1:0] tag_k, val_k;
  logic             tag_ge, tag_le, tag_eq, val_lt;

  // Storage: only the valid bit is reset; tag and value load on write.
  always_ff @(posedge clk) begin
    if (wr_hit) begin
      tag_q <= wr_tag;
      val_q <= wr_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         vld_q <= 1'b0;
    else if (wr_hit) vld_q <= 1'b1;
  end

  // Comparators against the broadcast key, widened to the key width.
  assign tag_k  = KEY_W'(tag_q);
  assign val_k  = KEY_W'(val_q);
  assign tag_ge = vld_q && (tag_k >= key);
  assign tag_le = vld_q && (tag_k <= key);
  assign tag_eq = vld_q && (tag_k == key);
  assign val_lt = val_k < key;

  always_comb begin
    sel_n  = sel_q;
    sav_n  = sav_q;
    less_n = less_q;
    unique case (op)
      OP_IDLE:     ;
      OP_SEL_ALL:  sel_n = 1'b1;
      OP_SEARCH: begin
        sel_n  = tag_eq;
        sav_n  = tag_eq;
        less_n = 1'b0;
      end
      OP_BOUND_LO: sel_n = sel_q && tag_ge;
      OP_BOUND_HI: sel_n = sel_q && tag_le;
      OP_SAVE: begin
        sav_n  = sel_q;
        less_n = 1'b0;
      end
      OP_COMPARE:  less_n = sav_q && val_lt;
      OP_CLEAR: begin
        sel_n  = 1'b0;
        sav_n  = 1'b0;
        less_n = 1'b0;
      end
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      sav_q  <= 1'b0;
      less_q <= 1'b0;
    end else begin
      sel_q  <= sel_n;
      sav_q  <= sav_n;
      less_q <= less_n;
    end
  end

  assign sel_o       = sel_q;
  assign saved_o     = sav_q;
  assign less_o      = less_q;
  assign saved_nxt_o = rst ? 1'b0 : sav_n;

endmodule

// File: rtl/assoc_any_reg.sv
module assoc_any_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vec,
  output logic             any_o
);

  // Registered reduction of the next-state saved vector, so the output
  // moves on the same edge as the saved flags themselves.
  always_ff @(posedge clk) begin
    if (rst) any_o <= 1'b0;
    else     any_o <= |vec;
  end

endmodule

// File: rtl/assoc_tag_array.sv
module assoc_tag_array
  import assoc_pkg::*;
#(
  parameter  int CELLS  = 16,
  parameter  int TAG_W  = 8,
  parameter  int VAL_W  = 8,
  localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int KEY_W  = (TAG_W > VAL_W) ? TAG_W : VAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_op,
  input  logic [KEY_W-1:0]  cmd_key,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [VAL_W-1:0]  wr_value,
  output logic [CELLS-1:0]  sel_flags,
  output logic [CELLS-1:0]  saved_flags,
  output logic [CELLS-1:0]  less_flags,
  output logic              any_match
);

  op_e              op;
  logic [CELLS-1:0] wr_hit;
  logic [CELLS-1:0] saved_nxt;

  assign op = op_e'(cmd_op);

  assoc_wr_decode #(
    .CELLS (CELLS),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_hit (wr_hit)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assoc_cell #(
      .TAG_W(TAG_W),
      .VAL_W(VAL_W),
      .KEY_W(KEY_W)
    ) u_cell (
      .clk        (clk),
      .rst        (rst),
      .wr_hit     (wr_hit[i]),
      .wr_tag     (wr_tag),
      .wr_value   (wr_value),
      .op         (op),
      .key        (cmd_key),
      .sel_o      (sel_flags[i]),
      .saved_o    (saved_flags[i]),
      .less_o     (less_flags[i]),
      .saved_nxt_o(saved_nxt[i])
    );
  end

  assoc_any_reg #(
    .WIDTH(CELLS)
  ) u_any (
    .clk  (clk),
    .rst  (rst),
    .vec  (saved_nxt),
    .any_o(any_match)
  );

endmodule

module assoc_tag_array_chk
  import assoc_pkg::*;
#(
  parameter int CELLS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd_op,
  input logic [CELLS-1:0] sel_flags,
  input logic [CELLS-1:0] saved_flags,
  input logic [CELLS-1:0] less_flags,
  input logic             any_match
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (sel_flags == '0 && saved_flags == '0 && less_flags == '0 && !any_match));

  p_sel_all_r3: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_SEL_ALL) |=> (sel_flags == '1));

  p_bound_narrow_r4_r5: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_BOUND_LO || op_e'(cmd_op) == OP_BOUND_HI)
      |=> ((sel_flags & ~$past(sel_flags)) == '0) && $stable(saved_flags));

  p_save_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_SAVE) |=> (saved_flags == $past(sel_flags)) && (less_flags == '0));

  p_compare_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_COMPARE) |=> $stable(sel_flags) && $stable(saved_flags));

  p_search_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_SEARCH) |=> (sel_flags == saved_flags) && (less_flags == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_CLEAR) |=> (sel_flags == '0 && saved_flags == '0 && less_flags == '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op_e'(cmd_op) == OP_IDLE)
      |=> $stable(sel_flags) && $stable(saved_flags) && $stable(less_flags));

  p_any_match_r11: assert property (@(posedge clk) disable iff (rst)
    any_match == (saved_flags != '0));

  p_less_in_saved_r11: assert property (@(posedge clk) disable iff (rst)
    (less_flags & ~saved_flags) == '0);

endmodule

bind assoc_tag_array assoc_tag_array_chk #(.CELLS(CELLS)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_op     (cmd_op),
  .sel_flags  (sel_flags),
  .saved_flags(saved_flags),
  .less_flags (less_flags),
  .any_match  (any_match)
);

// File: tb/test_assoc_tag_array.sv
module test_assoc_tag_array;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_key = 8'd0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_tag = 8'd0;
  logic [7:0] wr_value = 8'd0;
  logic [N-1:0] sel_flags, saved_flags, less_flags;
  logic       any_match;

  int checks = 0;
  int fails = 0;

  // Bench model of the cells and flags
  logic [7:0]   m_tag [N];
  logic [7:0]   m_val [N];
  logic [N-1:0] m_vld = '0;
  logic [N-1:0] m_sel = '0, m_sav = '0, m_less = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_tag_array i_assoc_tag_array (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_key(cmd_key),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_tag(wr_tag), .wr_value(wr_value),
    .sel_flags(sel_flags), .saved_flags(saved_flags), .less_flags(less_flags),
    .any_match(any_match)
  );

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'd0: return "R10";
      3'd1: return "R3";
      3'd2: return "R8";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "sel", sel_flags, m_sel);
    chk(req, "saved", saved_flags, m_sav);
    chk(req, "less", less_flags, m_less);
    chk("R11", "any_match", {15'd0, any_match}, {15'd0, (m_sav != '0)});
  endtask

  // Expected flags from the requirement text; the command sees old contents.
  task automatic model_cmd(input logic [2:0] op, input logic [7:0] key);
    for (int i = 0; i < N; i++) begin
      case (op)
        3'd1: m_sel[i] = 1'b1;
        3'd2: begin
          m_sel[i]  = m_vld[i] && (m_tag[i] == key);
          m_sav[i]  = m_sel[i];
          m_less[i] = 1'b0;
        end
        3'd3: m_sel[i] = m_sel[i] && m_vld[i] && (m_tag[i] >= key);
        3'd4: m_sel[i] = m_sel[i] && m_vld[i] && (m_tag[i] <= key);
        3'd5: begin
          m_sav[i]  = m_sel[i];
          m_less[i] = 1'b0;
        end
        3'd6: m_less[i] = m_sav[i] && (m_val[i] < key);
        3'd7: begin
          m_sel[i] = 1'b0; m_sav[i] = 1'b0; m_less[i] = 1'b0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] key,
                      input logic we, input logic [3:0] a,
                      input logic [7:0] t, input logic [7:0] v, input string req);
    @(negedge clk);
    cmd_op = op; cmd_key = key; wr_en = we; wr_addr = a; wr_tag = t; wr_value = v;
    @(posedge clk);
    model_cmd(op, key);
    if (we) begin
      m_tag[a] = t; m_val[a] = v; m_vld[a] = 1'b1;
    end
    #(CLK_PERIOD/4);
    cmd_op = 3'd0; wr_en = 1'b0;
    check_all(req);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] key);
    step(op, key, 1'b0, 4'd0, 8'd0, 8'd0, op_req(op));
  endtask

  task automatic split(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] s);
    cmd(3'd1, 8'd0);
    cmd(3'd3, lo);
    cmd(3'd4, hi);
    cmd(3'd5, 8'd0);
    cmd(3'd6, s);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) begin m_tag[i] = 8'd0; m_val[i] = 8'd0; end
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_all("R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #(CLK_PERIOD/4);
    check_all("R1");

    // R1: unwritten cells never pass a bound or a search
    step(3'd1, 8'd0, 1'b0, 4'd0, 8'd0, 8'd0, "R3");
    step(3'd3, 8'd0, 1'b0, 4'd0, 8'd0, 8'd0, "R1");
    step(3'd2, 8'd0, 1'b0, 4'd0, 8'd0, 8'd0, "R1");

    // R2: load cells, tag = 16*i, value = 10*i
    for (int i = 0; i < N; i++)
      step(3'd0, 8'd0, 1'b1, 4'(i), 8'(16*i), 8'(10*i), "R2");

    // R4/R5 inclusive bounds, R7 equal value gives not-less
    split(8'd32, 8'd96, 8'd40);
    chk("R7", "equal value not less", less_flags, 16'h000C);
    split(8'd100, 8'd50, 8'd200);   // crossed bounds: empty
    split(8'd0, 8'd255, 8'd0);      // all saved, none less
    split(8'd240, 8'd255, 8'd255);  // top cell only
    cmd(3'd6, 8'd151);              // R7 recompare on same saved set

    // R8 search hit and miss
    cmd(3'd2, 8'd48);
    chk("R8", "search hit cell 3", saved_flags, 16'h0008);
    cmd(3'd2, 8'd49);

    // R2 write in same cycle as search uses previous contents
    step(3'd2, 8'd77, 1'b1, 4'd5, 8'd77, 8'd9, "R2");
    chk("R2", "same-cycle write unseen", sel_flags, 16'h0000);
    step(3'd2, 8'd77, 1'b0, 4'd0, 8'd0, 8'd0, "R2");
    chk("R2", "write visible next", sel_flags, 16'h0020);

    cmd(3'd0, 8'd0);   // R10
    cmd(3'd7, 8'd0);   // R9
    cmd(3'd0, 8'd99);  // R10

    // Constrained random: narrow tag range to make matches likely
    for (int k = 0; k < 500; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] lo, hi;
        lo = 8'($urandom_range(0, 40));
        hi = 8'($urandom_range(0, 40));
        split(lo, hi, 8'($urandom_range(0, 40)));
      end else begin
        logic [2:0] op;
        logic       we;
        op = 3'($urandom_range(0, 7));
        we = ($urandom_range(0, 3) == 0);
        step(op, 8'($urandom_range(0, 40)), we, 4'($urandom_range(0, 15)),
             8'($urandom_range(0, 40)), 8'($urandom_range(0, 40)), op_req(op));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule